// File: doc/BRIEF.md
# Strobe-Framed Single-Slot Serial PCM Port

This block carries one byte in each direction every 8 kHz frame over a four-wire serial bus. The four wires are a bit clock, a framing strobe, a data input and a data output. An external controller raises the active-high strobe once per frame. The first rising bit-clock edge that sees the strobe high opens an 8-bit timeslot. In that slot the block shifts out the byte taken from the encoder and shifts in a byte for the decoder. Nothing sets the slot position except the strobe: there is no channel select and no bit offset.

A 3-bit rate code gives the expected bit-clock rate. At 512 kHz and above the port runs synchronously: the bit clock also times the decoder-side valid pulse and the frame tick. At 128 kHz and 256 kHz a separate 4.096 MHz master clock is needed. In that case the received byte crosses into the master domain through a two-flop synchronized toggle handshake, and the frame tick comes from the strobe after it has been resynchronized in that domain. This lets the internal timing follow the strobe again on every frame. Two mute inputs force the outgoing or the incoming byte to the quiet code 8'h7F.

The serial side is a pair of state machines clocked by the bit clock. The transmit machine runs on the rising edge and has two states. It moves from SLOT_IDLE to SLOT_SHIFT when it sees the strobe, and from SLOT_SHIFT back to SLOT_IDLE after the eighth bit period. The receive counter runs on the falling edge. The master-clock bridge also has two states. It moves from XFER_IDLE to XFER_EMIT on a synchronized toggle edge, and from XFER_EMIT back to XFER_IDLE on the next master cycle.

Top module: `pcm_strobe_port`

## Requirements
- R1: `bus_drive` is low outside the slot. It goes high at the rising bit-clock edge that first samples `strobe` high and stays high for exactly 8 bit periods. At the rising edge that ends the eighth period it returns low, and `sdout` is treated as high-impedance while `bus_drive` is low.
- R2: The transmit byte is captured at the slot-opening edge. It leaves most significant bit first, and `sdout` changes only on rising bit-clock edges, so bit 7-i is driven during bit period i.
- R3: When `tx_mute` is 1 at the slot-opening edge, the slot carries 8'h7F in place of `tx_byte`.
- R4: `sdin` is sampled on the 8 falling bit-clock edges inside the slot. The first sample becomes bit 7 of the received byte, which is presented on `rx_data`.
- R5: When `rx_mute` is 1 at the eighth falling edge of the slot, the delivered received byte is 8'h7F whatever `sdin` carried.
- R6: Rate codes 3'b000 (128 kHz) and 3'b001 (256 kHz) select asynchronous operation. Codes 3'b010 (512), 3'b011 (1536), 3'b100 (2048) and 3'b101 (4096 kHz) select synchronous operation, and so do the unused codes 3'b110 and 3'b111, which are treated as 2048 kHz.
- R7: In synchronous mode `rx_valid` is high for one bit period, from the eighth falling edge of the slot to the next falling edge, so the rising edge that closes the slot sees it. `frame_tick` is high for the one bit period that follows the slot-opening edge.
- R8: In asynchronous mode each slot produces exactly one `rx_valid` pulse, one master-clock cycle wide, with the received byte on `rx_data`. The pulse comes after a two-flop synchronizer.
- R9: In asynchronous mode each rising edge of `strobe` produces exactly one `frame_tick` pulse, one master-clock cycle wide, after resynchronization to the master clock.
- R10: While `rst_n` is low and just after its release, `bus_drive`, `rx_valid` and `frame_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock |
| clk_mst | input | 1 | 4.096 MHz master clock, used at the two lowest rates |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Bit-clock rate code |
| strobe | input | 1 | Active-high framing strobe that marks the slot |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data, valid while bus_drive is high |
| bus_drive | output | 1 | Output enable for the external tri-state pad |
| tx_byte | input | 8 | Byte from the encoder |
| tx_mute | input | 1 | Forces the transmitted byte to the quiet code |
| rx_mute | input | 1 | Forces the received byte to the quiet code |
| rx_data | output | 8 | Byte to the decoder |
| rx_valid | output | 1 | Marks a new rx_data, timed by the active domain |
| frame_tick | output | 1 | One pulse per frame, timed by the active domain |

## Verification
If the slot counter goes wrong, `bus_drive` is high for a wrong number of bit periods, or the bits on `sdout` come out rotated within the same frame. A broken receive shifter or mute multiplexer shows up as a wrong `rx_data` at the rising edge that closes the slot. A stuck or skipped handshake state in the master domain shows up within a dozen master cycles after the slot, as a missing or doubled `rx_valid` or `frame_tick` pulse. The sweep runs every rate code against every combination of the two mutes, so a wrong rate decode shows up as valid timing in the wrong domain.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [2:0] {
        RATE_128  = 3'd0,
        RATE_256  = 3'd1,
        RATE_512  = 3'd2,
        RATE_1536 = 3'd3,
        RATE_2048 = 3'd4,
        RATE_4096 = 3'd5
    } rate_e;

    typedef enum logic {
        SLOT_IDLE  = 1'b0,
        SLOT_SHIFT = 1'b1
    } slot_state_e;

    typedef enum logic {
        XFER_IDLE = 1'b0,
        XFER_EMIT = 1'b1
    } xfer_state_e;

endpackage

// File: rtl/pcm_rate_decode.sv
module pcm_rate_decode
    import pcm_port_pkg::*;
(
    input  logic [2:0] rate_sel,
    output logic       async_mode
);

    rate_e rate;

    always_comb begin
        unique case (rate_sel)
            3'b000:  rate = RATE_128;
            3'b001:  rate = RATE_256;
            3'b010:  rate = RATE_512;
            3'b011:  rate = RATE_1536;
            3'b100:  rate = RATE_2048;
            3'b101:  rate = RATE_4096;
            default: rate = RATE_2048;
        endcase
    end

    // Below 512 kHz the bit clock is too slow to time internal functions.
    always_comb begin
        unique case (rate)
            RATE_128, RATE_256: async_mode = 1'b1;
            default:            async_mode = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcm_slot_engine.sv
module pcm_slot_engine
    import pcm_port_pkg::*;
#(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] QUIET  = {1'b0, {(DATA_W-1){1'b1}}}
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              sdin,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_mute,
    input  logic              rx_mute,
    output logic              sdout,
    output logic              drive,
    output logic              tick_b,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid_b,
    output logic              rx_toggle
);

    localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    slot_state_e       tx_state, tx_next;
    logic [DATA_W-1:0] tx_sh;
    logic [CW-1:0]     tx_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [CW-1:0]     rx_cnt;

    // Transmit state register (rising edge)
    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) tx_state <= SLOT_IDLE;
        else        tx_state <= tx_next;
    end

    always_comb begin
        tx_next = tx_state;
        unique case (tx_state)
            SLOT_IDLE:  if (strobe)         tx_next = SLOT_SHIFT;
            SLOT_SHIFT: if (tx_cnt == LAST) tx_next = SLOT_IDLE;
            default:                        tx_next = SLOT_IDLE;
        endcase
    end

    // Transmit datapath: load at slot open, shift MSB first
    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            tx_cnt <= '0;
            tick_b <= 1'b0;
        end else begin
            tick_b <= (tx_state == SLOT_IDLE) && strobe;
            unique case (tx_state)
                SLOT_IDLE: begin
                    tx_cnt <= '0;
                    if (strobe) tx_sh <= tx_mute ? QUIET : tx_byte;
                end
                SLOT_SHIFT: begin
                    tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                    tx_cnt <= tx_cnt + 1'b1;
                end
                default: tx_cnt <= '0;
            endcase
        end
    end

    // Output decode
    always_comb begin
        drive = (tx_state == SLOT_SHIFT);
        sdout = drive ? tx_sh[DATA_W-1] : 1'b0;
    end

    // Receive path (falling edge) samples inside the slot
    always_ff @(negedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh      <= '0;
            rx_cnt     <= '0;
            rx_byte    <= '0;
            rx_valid_b <= 1'b0;
            rx_toggle  <= 1'b0;
        end else if (tx_state == SLOT_SHIFT) begin
            rx_sh <= {rx_sh[DATA_W-2:0], sdin};
            if (rx_cnt == LAST) begin
                rx_cnt     <= '0;
                rx_byte    <= rx_mute ? QUIET : {rx_sh[DATA_W-2:0], sdin};
                rx_valid_b <= 1'b1;
                rx_toggle  <= ~rx_toggle;
            end else begin
                rx_cnt     <= rx_cnt + 1'b1;
                rx_valid_b <= 1'b0;
            end
        end else begin
            rx_cnt     <= '0;
            rx_valid_b <= 1'b0;
        end
    end

endmodule

// File: rtl/pcm_async_bridge.sv
module pcm_async_bridge
    import pcm_port_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_mst,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              rx_toggle,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] rx_data_m,
    output logic              rx_valid_m,
    output logic              tick_m
);

    localparam int TOP = SYNC_STAGES;

    logic [TOP:0] tg_q;
    logic [TOP:0] sb_q;
    logic         tg_edge;
    xfer_state_e  x_state, x_next;

    // Synchronizer chains, one extra flop keeps history for edge detect
    always_ff @(posedge clk_mst or negedge rst_n) begin
        if (!rst_n) begin
            tg_q <= '0;
            sb_q <= '0;
        end else begin
            tg_q <= {tg_q[TOP-1:0], rx_toggle};
            sb_q <= {sb_q[TOP-1:0], strobe};
        end
    end

    assign tg_edge = tg_q[TOP] ^ tg_q[TOP-1];

    always_ff @(posedge clk_mst or negedge rst_n) begin
        if (!rst_n) x_state <= XFER_IDLE;
        else        x_state <= x_next;
    end

    always_comb begin
        x_next = x_state;
        unique case (x_state)
            XFER_IDLE: if (tg_edge) x_next = XFER_EMIT;
            XFER_EMIT:              x_next = XFER_IDLE;
            default:                x_next = XFER_IDLE;
        endcase
    end

    // Outputs: byte captured on handshake edge, frame tick from strobe rise
    always_ff @(posedge clk_mst or negedge rst_n) begin
        if (!rst_n) begin
            rx_data_m <= '0;
            tick_m    <= 1'b0;
        end else begin
            tick_m <= sb_q[TOP-1] & ~sb_q[TOP];
            if (x_state == XFER_IDLE && tg_edge) rx_data_m <= rx_byte;
        end
    end

    assign rx_valid_m = (x_state == XFER_EMIT);

endmodule

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port
    import pcm_port_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] QUIET       = {1'b0, {(DATA_W-1){1'b1}}},
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk_bit,
    input  logic              clk_mst,
    input  logic              rst_n,
    input  logic [2:0]        rate_sel,
    input  logic              strobe,
    input  logic              sdin,
    output logic              sdout,
    output logic              bus_drive,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_mute,
    input  logic              rx_mute,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_tick
);

    logic              async_mode;
    logic              tick_b, rx_valid_b, rx_toggle;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] rx_data_m;
    logic              rx_valid_m, tick_m;

    pcm_rate_decode u_rate (
        .rate_sel   (rate_sel),
        .async_mode (async_mode)
    );

    pcm_slot_engine #(.DATA_W(DATA_W), .QUIET(QUIET)) u_slot (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .sdin       (sdin),
        .tx_byte    (tx_byte),
        .tx_mute    (tx_mute),
        .rx_mute    (rx_mute),
        .sdout      (sdout),
        .drive      (bus_drive),
        .tick_b     (tick_b),
        .rx_byte    (rx_byte),
        .rx_valid_b (rx_valid_b),
        .rx_toggle  (rx_toggle)
    );

    pcm_async_bridge #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_bridge (
        .clk_mst    (clk_mst),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .rx_toggle  (rx_toggle),
        .rx_byte    (rx_byte),
        .rx_data_m  (rx_data_m),
        .rx_valid_m (rx_valid_m),
        .tick_m     (tick_m)
    );

    // Decoder-side outputs follow the domain picked by the rate code
    always_comb begin
        rx_data    = async_mode ? rx_data_m  : rx_byte;
        rx_valid   = async_mode ? rx_valid_m : rx_valid_b;
        frame_tick = async_mode ? tick_m     : tick_b;
    end

endmodule

// File: rtl/pcm_strobe_port_chk.sv
module pcm_strobe_port_chk #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] QUIET  = {1'b0, {(DATA_W-1){1'b1}}}
) (
    input logic       clk_bit,
    input logic       clk_mst,
    input logic       rst_n,
    input logic [2:0] rate_sel,
    input logic       tx_mute,
    input logic       sdout,
    input logic       bus_drive,
    input logic       rx_valid,
    input logic       frame_tick
);

    logic [7:0] run_cnt;
    logic       slow_rate;

    assign slow_rate = (rate_sel == 3'b000) || (rate_sel == 3'b001);

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n)         run_cnt <= '0;
        else if (bus_drive) run_cnt <= (run_cnt == 8'hFF) ? run_cnt : run_cnt + 1'b1;
        else                run_cnt <= '0;
    end

    // R1: the pad enable never lasts longer than one slot
    assert_slot_len_R1: assert property (@(posedge clk_bit) disable iff (!rst_n)
        run_cnt <= 8'(DATA_W));

    // R3: a muted slot starts with the quiet code's top bit
    assert_quiet_msb_R3: assert property (@(posedge clk_bit) disable iff (!rst_n)
        ($rose(bus_drive) && $past(tx_mute)) |-> (sdout == QUIET[DATA_W-1]));

    // R7: synchronous valid lasts a single bit period
    assert_sync_valid_R7: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (!slow_rate && $stable(rate_sel) && rx_valid) |=> (!rx_valid || slow_rate));

    // R8: asynchronous valid is a single master cycle
    assert_async_valid_R8: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (slow_rate && rx_valid) |=> (!rx_valid || !slow_rate));

    // R9: asynchronous frame tick is a single master cycle
    assert_async_tick_R9: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (slow_rate && frame_tick) |=> (!frame_tick || !slow_rate));

endmodule

bind pcm_strobe_port pcm_strobe_port_chk #(.DATA_W(DATA_W), .QUIET(QUIET)) u_chk (
    .clk_bit    (clk_bit),
    .clk_mst    (clk_mst),
    .rst_n      (rst_n),
    .rate_sel   (rate_sel),
    .tx_mute    (tx_mute),
    .sdout      (sdout),
    .bus_drive  (bus_drive),
    .rx_valid   (rx_valid),
    .frame_tick (frame_tick)
);

// File: tb/pcm_strobe_port_bench.sv
`timescale 1ns/1ps
module pcm_strobe_port_bench;

    logic       clk_mst = 1'b0;
    logic       clk_bit = 1'b0;
    logic       rst_n   = 1'b0;
    logic [2:0] rate_sel = 3'b100;
    logic       strobe  = 1'b0;
    logic       sdin    = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_mute = 1'b0;
    logic       rx_mute = 1'b0;
    logic       sdout, bus_drive, rx_valid, frame_tick;
    logic [7:0] rx_data;

    int   vectors = 0;
    int   miss    = 0;
    bit   done    = 1'b0;
    bit   mon_en  = 1'b0;
    int   vcnt    = 0;
    int   tcnt    = 0;
    logic [7:0] vdata = 8'h00;

    always #4 clk_mst = ~clk_mst;

    pcm_strobe_port u_pcm_strobe_port (
        .clk_bit    (clk_bit),
        .clk_mst    (clk_mst),
        .rst_n      (rst_n),
        .rate_sel   (rate_sel),
        .strobe     (strobe),
        .sdin       (sdin),
        .sdout      (sdout),
        .bus_drive  (bus_drive),
        .tx_byte    (tx_byte),
        .tx_mute    (tx_mute),
        .rx_mute    (rx_mute),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .frame_tick (frame_tick)
    );

    // Master-domain pulse monitor, sampled on the falling master edge
    always @(negedge clk_mst) begin
        if (mon_en) begin
            if (rx_valid) begin
                vcnt  = vcnt + 1;
                vdata = rx_data;
            end
            if (frame_tick) tcnt = tcnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [2:0] rs, input logic [7:0] tx, input logic [7:0] rx,
                             input logic tm, input logic rm);
        int         h;
        logic       slow;
        logic [7:0] txe;
        logic [7:0] rxe;
        slow = (rs == 3'b000) || (rs == 3'b001);
        h    = (rs == 3'b000) ? 128 : (rs == 3'b001) ? 64 : 16;
        txe  = tm ? 8'h7F : tx;
        rxe  = rm ? 8'h7F : rx;
        rate_sel = rs;
        tx_byte  = tx;
        tx_mute  = tm;
        rx_mute  = rm;
        #(h);
        vcnt   = 0;
        tcnt   = 0;
        mon_en = slow;
        chk("R1 idle enable", 32'(bus_drive), 32'd0);
        strobe = 1'b1;
        sdin   = rx[7];
        #(h);
        clk_bit = 1'b1;
        #1;
        if (!slow) chk("R7 sync frame tick", 32'(frame_tick), 32'd1);
        for (int i = 0; i < 8; i++) begin
            chk("R2/R3 tx bit", 32'(sdout), 32'(txe[7-i]));
            chk("R1 enable in slot", 32'(bus_drive), 32'd1);
            if (i == 1 && !slow) chk("R7 tick cleared", 32'(frame_tick), 32'd0);
            #(h - 1);
            clk_bit = 1'b0;
            #1;
            if (i == 0) strobe = 1'b0;
            if (i < 7) sdin = rx[6-i];
            #(h - 1);
            clk_bit = 1'b1;
            #1;
        end
        chk("R1 enable after slot", 32'(bus_drive), 32'd0);
        if (!slow) begin
            chk("R6/R7 sync valid", 32'(rx_valid), 32'd1);
            chk("R4/R5 sync data", 32'(rx_data), 32'(rxe));
        end
        #(h - 1);
        clk_bit = 1'b0;
        #(h);
        if (slow) begin
            repeat (12) @(negedge clk_mst);
            chk("R6/R8 async valid count", 32'(vcnt), 32'd1);
            chk("R4/R5 async data", 32'(vdata), 32'(rxe));
            chk("R9 async tick count", 32'(tcnt), 32'd1);
            mon_en = 1'b0;
        end else begin
            chk("R7 sync valid cleared", 32'(rx_valid), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk_mst);
        chk("R10 reset enable", 32'(bus_drive), 32'd0);
        chk("R10 reset valid", 32'(rx_valid), 32'd0);
        chk("R10 reset tick", 32'(frame_tick), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_mst);
        chk("R10 post-reset enable", 32'(bus_drive), 32'd0);
        chk("R10 post-reset valid", 32'(rx_valid), 32'd0);
        for (int rs = 0; rs < 8; rs++) begin
            for (int m = 0; m < 4; m++) begin
                for (int b = 0; b < 3; b++) begin
                    logic [7:0] tx;
                    logic [7:0] rx;
                    tx = (b == 0) ? 8'h00 : (b == 1) ? 8'hFF : 8'(rs * 37 + m * 13 + 8'h5A);
                    rx = (b == 0) ? 8'hFF : (b == 1) ? 8'h80 : 8'(~(rs * 29 + m * 7) ^ 8'h33);
                    run_frame(3'(rs), tx, rx, m[0], m[1]);
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            vectors++;
            miss++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end

endmodule